// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into system memory through a ring of two-word receive descriptors. Software prepares each descriptor with a buffer address whose bit 0 is clear and a second word of zero, then enables reception. On the first byte of a frame the engine reads the address word of the current descriptor. If that descriptor is free, the engine packs the incoming bytes into 32-bit words and writes them into the buffer. At the end of the frame it writes the length into the second word and then sets the ownership bit in the address word.

The ring starts at a programmed base address. A descriptor whose bit 1 is set is the last one in the ring, and the engine returns to the base after filling it. A frame that meets a descriptor still held by software is consumed and counted as dropped. Bytes that do not fit the buffer are discarded. A small register slice holds the receive enable, the ring base and the buffer size in 64-byte units. The memory side is a simple request/acknowledge word master with byte strobes.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, drop_count is 0 and mem_req is 0. Register reads return 0 at offset 0x000, 0x0018_0000 at offset 0x010 (a buffer field of 24, which is 1536 bytes) and 0 at offset 0x018.
- R2: The receive enable is bit 2 at offset 0x000. The buffer size field is bits 23:16 at offset 0x010, counted in 64-byte units. The ring base is at offset 0x018, and its bits 2:0 read as zero. All other bits read as zero.
- R3: On the first byte of a frame the engine reads the word at the current pointer. If bit 0 of that word is clear, the buffer address is the word with bits 1:0 cleared. A byte is taken on a clock where in_valid and in_ready are both high. Byte n of the frame lands at buffer address + n, little-endian within each word, and only the strobe lanes of real bytes are written.
- R4: After the last byte the engine writes the frame length into bits 12:0 of the word at pointer + 4, with the upper bits zero. Only after that does it write the address word back with bit 0 set and all other bits unchanged.
- R5: After a descriptor is filled, the pointer moves on by 8 bytes. If bit 1 of the address word is set, the pointer returns to the ring base instead.
- R6: If bit 0 of the fetched address word is set, the whole frame is consumed without any memory write. drop_count goes up by one and the pointer stays where it is.
- R7: Bytes beyond the buffer size are discarded and the length written back is capped at the buffer size. Field values above 127 act as 127 (8128 bytes).
- R8: While reception is disabled and no frame is in progress, the pointer reloads the ring base. Bytes arriving in that state are consumed with no memory access and no drop count.
- R9: Once mem_req is raised, it stays high with stable mem_addr, mem_we, mem_wdata and mem_wstrb until the clock on which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Engine takes the byte this clock |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Request completed this clock |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| drop_count | output | DROP_W | Frames dropped because the descriptor was owned by software |

## Verification
The bench sends a frame whose length is not a multiple of four. A design with wrong strobes would overwrite the sentinel bytes after the frame. It also watches the write order on the bus. If the ownership bit were written before the length, software could read a stale length. It fills the last descriptor and checks that the next frame lands in the first one, not past the end of the ring. It aims a frame at a descriptor still owned by software; a design that got this wrong would overwrite a buffer in use or move the pointer past it. It overflows both a 64-byte buffer and a clamped 8128-byte buffer, and checks the capped length and the untouched word past the end. Finally it disables reception with the pointer on an owned descriptor and confirms that the next frame goes back to the base and is not dropped.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int STRB_W      = DATA_W / 8;
    localparam int LEN_W       = 13;
    localparam int LEN_CNT_W   = 14;
    localparam int FIELD_W     = 8;
    localparam int UNIT_SHIFT  = 6;
    localparam int DESC_STRIDE = 8;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_DMA   = 8'h10;
    localparam logic [7:0] OFS_QBASE = 8'h18;

    localparam int RXEN_BIT     = 2;
    localparam int FIELD_LSB    = 16;
    localparam int SW_OWN_BIT   = 0;
    localparam int RING_END_BIT = 1;

    localparam logic [FIELD_W-1:0] FIELD_RESET = 8'd24;
    localparam logic [FIELD_W-1:0] FIELD_MAX   = 8'd127;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RECV,
        ST_DATA,
        ST_FLAGS,
        ST_OWN,
        ST_DISCARD
    } rx_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] wstrb;
    } mem_cmd_t;

    function automatic logic [LEN_CNT_W-1:0] field_to_bytes(input logic [FIELD_W-1:0] f);
        logic [FIELD_W-1:0] c;
        c = (f > FIELD_MAX) ? FIELD_MAX : f;
        return {c, {UNIT_SHIFT{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
    import rx_ring_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 rx_en,
    output logic [ADDR_W-1:0]    q_base,
    output logic [FIELD_W-1:0]   buf_field
);

    logic wr_ctrl, wr_dma, wr_base;

    assign wr_ctrl = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
    assign wr_dma  = reg_we && (reg_addr == REG_AW'(OFS_DMA));
    assign wr_base = reg_we && (reg_addr == REG_AW'(OFS_QBASE));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en     <= 1'b0;
            q_base    <= '0;
            buf_field <= FIELD_RESET;
        end else begin
            if (wr_ctrl) rx_en     <= reg_wdata[RXEN_BIT];
            if (wr_dma)  buf_field <= reg_wdata[FIELD_LSB +: FIELD_W];
            if (wr_base) q_base    <= {reg_wdata[ADDR_W-1:3], 3'b000};
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_CTRL))
            reg_rdata[RXEN_BIT] = rx_en;
        else if (reg_addr == REG_AW'(OFS_DMA))
            reg_rdata[FIELD_LSB +: FIELD_W] = buf_field;
        else if (reg_addr == REG_AW'(OFS_QBASE))
            reg_rdata = q_base;
    end

    // R2: a write to the size field shows up in the register the next cycle
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == REG_AW'(OFS_DMA)) |=> (buf_field == $past(reg_wdata[FIELD_LSB +: FIELD_W])));

    // R2: the ring base is always aligned to a descriptor
    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        q_base[2:0] == 3'b000);

endmodule

// File: rtl/rx_ring_track.sv
module rx_ring_track
    import rx_ring_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_en,
    input  logic                 idle,
    input  logic [ADDR_W-1:0]    q_base,
    input  logic                 advance,
    input  logic                 wrap,
    input  logic                 drop_inc,
    output logic [ADDR_W-1:0]    ptr,
    output logic [DROP_W-1:0]    drop_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (idle && !rx_en) begin
            ptr <= q_base;
        end else if (advance) begin
            ptr <= wrap ? q_base : ptr + ADDR_W'(DESC_STRIDE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            drop_count <= '0;
        else if (drop_inc)
            drop_count <= drop_count + DROP_W'(1);
    end

    // R5: the pointer only ever steps one descriptor or jumps back to the base
    assert_ptr_move_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> ((ptr == $past(ptr) + ADDR_W'(DESC_STRIDE)) || (ptr == $past(q_base))));

    // R8: disabled and idle means the pointer sits on the base next cycle
    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (idle && !rx_en) |=> (ptr == $past(q_base)));

    // R6: the drop counter moves by one at a time
    assert_drop_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(drop_count) |-> (drop_count == $past(drop_count) + DROP_W'(1)));

endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
    import rx_ring_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_en,
    input  logic [ADDR_W-1:0]     ptr,
    input  logic [LEN_CNT_W-1:0]  buf_bytes,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata,
    output mem_cmd_t              cmd,
    output logic                  idle,
    output logic                  advance,
    output logic                  wrap,
    output logic                  drop_inc
);

    rx_state_e             state_q, state_d;
    logic [DATA_W-1:0]     desc_q, desc_d;
    logic [LEN_CNT_W-1:0]  len_q, len_d;
    logic [LEN_CNT_W-1:0]  off_q, off_d;
    logic [DATA_W-1:0]     acc_q, acc_d;
    logic [STRB_W-1:0]     strb_q, strb_d;
    logic                  last_q, last_d;
    logic [ADDR_W-1:0]     buf_base;
    logic [1:0]            lane;

    assign buf_base = align_word(desc_q[ADDR_W-1:0]);
    assign lane     = len_q[1:0];
    assign idle     = (state_q == ST_IDLE);
    assign wrap     = desc_q[RING_END_BIT];

    always_comb begin
        state_d  = state_q;
        desc_d   = desc_q;
        len_d    = len_q;
        off_d    = off_q;
        acc_d    = acc_q;
        strb_d   = strb_q;
        last_d   = last_q;
        cmd      = '0;
        in_ready = 1'b0;
        advance  = 1'b0;
        drop_inc = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!rx_en) begin
                    in_ready = 1'b1;
                    if (in_valid && !in_last) state_d = ST_DISCARD;
                end else if (in_valid) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                cmd.req  = 1'b1;
                cmd.addr = ptr;
                if (mem_ack) begin
                    desc_d = mem_rdata;
                    if (mem_rdata[SW_OWN_BIT]) begin
                        drop_inc = 1'b1;
                        state_d  = ST_DISCARD;
                    end else begin
                        len_d   = '0;
                        acc_d   = '0;
                        strb_d  = '0;
                        last_d  = 1'b0;
                        state_d = ST_RECV;
                    end
                end
            end
            ST_RECV: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    last_d = in_last;
                    if (len_q < buf_bytes) begin
                        acc_d[{lane, 3'b000} +: 8] = in_data;
                        strb_d[lane] = 1'b1;
                        len_d = len_q + LEN_CNT_W'(1);
                        off_d = {len_q[LEN_CNT_W-1:2], 2'b00};
                        if (lane == 2'd3 || in_last) state_d = ST_DATA;
                    end else if (in_last) begin
                        state_d = ST_FLAGS;
                    end
                end
            end
            ST_DATA: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = buf_base + ADDR_W'(off_q);
                cmd.wdata = acc_q;
                cmd.wstrb = strb_q;
                if (mem_ack) begin
                    acc_d   = '0;
                    strb_d  = '0;
                    state_d = last_q ? ST_FLAGS : ST_RECV;
                end
            end
            ST_FLAGS: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = ptr + ADDR_W'(4);
                cmd.wdata = DATA_W'(len_q[LEN_W-1:0]);
                cmd.wstrb = '1;
                if (mem_ack) state_d = ST_OWN;
            end
            ST_OWN: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = ptr;
                cmd.wdata = desc_q | DATA_W'(1 << SW_OWN_BIT);
                cmd.wstrb = '1;
                if (mem_ack) begin
                    advance = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DISCARD: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            len_q   <= '0;
            off_q   <= '0;
            acc_q   <= '0;
            strb_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            desc_q  <= desc_d;
            len_q   <= len_d;
            off_q   <= off_d;
            acc_q   <= acc_d;
            strb_q  <= strb_d;
            last_q  <= last_d;
        end
    end

    // R9: a pending request is held unchanged until acknowledged
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && !mem_ack) |=> (cmd.req && $stable(cmd.addr) && $stable(cmd.we)
                                   && $stable(cmd.wdata) && $stable(cmd.wstrb)));

    // R7: the written-back length never exceeds the buffer size
    assert_len_cap_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLAGS) |-> (LEN_CNT_W'(cmd.wdata[LEN_W-1:0]) <= buf_bytes));

    // R4: the ownership write is only reached straight from the length write
    assert_own_after_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OWN) |-> ($past(state_q) == ST_FLAGS || $past(state_q) == ST_OWN));

    // R3: data writes stay inside the buffer
    assert_data_in_buf_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (off_q < buf_bytes && strb_q != '0));

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rx_ring_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DROP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    output logic [3:0]           mem_wstrb,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic [DROP_W-1:0]    drop_count
);

    logic                  rx_en;
    logic [ADDR_W-1:0]     q_base;
    logic [FIELD_W-1:0]    buf_field;
    logic [LEN_CNT_W-1:0]  buf_bytes;
    logic [ADDR_W-1:0]     ptr;
    logic                  idle, advance, wrap, drop_inc;
    mem_cmd_t              cmd;

    assign buf_bytes = field_to_bytes(buf_field);

    rx_ring_regs #(.REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_en     (rx_en),
        .q_base    (q_base),
        .buf_field (buf_field)
    );

    rx_ring_track #(.DROP_W(DROP_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .idle       (idle),
        .q_base     (q_base),
        .advance    (advance),
        .wrap       (wrap),
        .drop_inc   (drop_inc),
        .ptr        (ptr),
        .drop_count (drop_count)
    );

    rx_ring_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .ptr       (ptr),
        .buf_bytes (buf_bytes),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .cmd       (cmd),
        .idle      (idle),
        .advance   (advance),
        .wrap      (wrap),
        .drop_inc  (drop_inc)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign mem_wstrb = cmd.wstrb;

endmodule

// File: tb/test_rx_ring_engine.sv
module test_rx_ring_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic [15:0] drop_count;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int order_err = 0;
    int hold_err = 0;
    int cycles = 0;

    logic [31:0] mem [0:4095];
    logic [31:0] last_wr_addr;

    always #10 clk = ~clk;

    rx_ring_engine i_rx_ring_engine (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .drop_count(drop_count)
    );

    // memory model: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                wr_count <= wr_count + 1;
                if (mem_wdata[0] && mem_addr[2:0] == 3'b000 && mem_addr < 32'h200
                    && last_wr_addr != mem_addr + 32'd4)
                    order_err <= order_err + 1;
                last_wr_addr <= mem_addr;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // request hold monitor
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    always @(negedge clk) begin
        if (!rst && p_req && !p_ack) begin
            if (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata)
                hold_err = hold_err + 1;
        end
        p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: all requirements, got %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic l);
        in_valid = 1'b1; in_data = b; in_last = l;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_frame(input int n, input int first);
        for (int i = 0; i < n; i++) send_byte(8'((first + i) & 255), i == n - 1);
        repeat (20) @(negedge clk);
    endtask

    function automatic logic [31:0] w(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    task automatic arm(input logic [31:0] d, input logic [31:0] addr_word);
        mem[d[13:2]] = addr_word;
        mem[d[13:2] + 1] = 32'h0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 drop_count", 32'(drop_count), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        reg_read(8'h00, r); chk("R1 control", r, 32'h0);
        reg_read(8'h10, r); chk("R1 buffer size", r, 32'h0018_0000);
        reg_read(8'h18, r); chk("R1 base", r, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] r;
        reg_write(8'h18, 32'h0000_0107);
        reg_read(8'h18, r); chk("R2 base aligned", r, 32'h0000_0100);
        reg_write(8'h10, 32'hFF01_FFFF);
        reg_read(8'h10, r); chk("R2 size field only", r, 32'h0001_0000);
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, r); chk("R2 enable bit only", r, 32'h0000_0004);
    endtask

    task automatic t_basic();
        arm(32'h100, 32'h0000_1000);
        arm(32'h108, 32'h0000_1102);
        mem[32'h1008 >> 2] = 32'hAAAA_AAAA;
        send_frame(10, 8'h10);
        chk("R3 first word", w(32'h1000), 32'h1312_1110);
        chk("R3 second word", w(32'h1004), 32'h1716_1514);
        chk("R3 partial word strobes", w(32'h1008), 32'hAAAA_1918);
        chk("R4 length", w(32'h104), 32'd10);
        chk("R4 owned address word", w(32'h100), 32'h0000_1001);
        chk("R4 length before ownership", 32'(order_err), 32'd0);
    endtask

    task automatic t_wrap();
        mem[32'h114 >> 2] = 32'h5A5A_5A5A;
        send_frame(5, 8'h40);
        chk("R4 wrap descriptor length", w(32'h10C), 32'd5);
        chk("R4 wrap bit kept", w(32'h108), 32'h0000_1103);
        arm(32'h100, 32'h0000_1000);
        send_frame(3, 8'h60);
        chk("R5 returned to base", w(32'h104), 32'd3);
        chk("R5 base buffer data", w(32'h1000) & 32'h00FF_FFFF, 32'h0062_6160);
        chk("R5 no write past ring end", w(32'h114), 32'h5A5A_5A5A);
    endtask

    task automatic t_drop();
        int wc;
        wc = wr_count;
        send_frame(4, 8'h70);
        chk("R6 drop counted", 32'(drop_count), 32'd1);
        chk("R6 no writes", 32'(wr_count - wc), 32'd0);
        chk("R6 descriptor untouched", w(32'h10C), 32'd5);
        arm(32'h108, 32'h0000_1102);
        send_frame(2, 8'h80);
        chk("R6 pointer held", w(32'h10C), 32'd2);
        chk("R6 retry data", w(32'h1100) & 32'h0000_FFFF, 32'h0000_8180);
    endtask

    task automatic t_overflow();
        arm(32'h100, 32'h0000_1000);
        mem[32'h1040 >> 2] = 32'h5555_5555;
        send_frame(70, 0);
        chk("R7 length capped", w(32'h104), 32'd64);
        chk("R7 last stored word", w(32'h103C), 32'h3F3E_3D3C);
        chk("R7 beyond buffer untouched", w(32'h1040), 32'h5555_5555);
    endtask

    task automatic t_disable();
        int wc;
        reg_write(8'h00, 32'h0);
        wc = wr_count;
        for (int i = 0; i < 6; i++) send_byte(8'hEE, i == 5);
        repeat (10) @(negedge clk);
        chk("R8 disabled: no memory access", 32'(wr_count - wc), 32'd0);
        chk("R8 disabled: no drop", 32'(drop_count), 32'd1);
        arm(32'h100, 32'h0000_1000);
        reg_write(8'h00, 32'h4);
        send_frame(4, 8'hC0);
        chk("R8 pointer back at base", w(32'h104), 32'd4);
        chk("R8 base owned", w(32'h100), 32'h0000_1001);
        chk("R8 not dropped", 32'(drop_count), 32'd1);
    endtask

    task automatic t_big();
        logic [31:0] r;
        reg_write(8'h00, 32'h0);
        arm(32'h100, 32'h0000_1800);
        mem[32'h37C0 >> 2] = 32'h7777_7777;
        reg_write(8'h10, 32'h00C8_0000);
        reg_read(8'h10, r); chk("R2 field 200 reads back", r, 32'h00C8_0000);
        reg_write(8'h00, 32'h4);
        send_frame(8200, 0);
        chk("R7 clamped length", w(32'h104), 32'd8128);
        chk("R7 clamped last word", w(32'h37BC), 32'hBFBE_BDBC);
        chk("R7 clamped end untouched", w(32'h37C0), 32'h7777_7777);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        last_wr_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_wrap();
        t_drop();
        t_overflow();
        t_disable();
        t_big();
        chk("R9 request held until ack", 32'(hold_err), 32'd0);
        finish_run();
    end

endmodule